// File: doc/BRIEF.md
# Dispatch Steering Unit

This unit takes one group of renamed instructions per cycle, up to `N_SLOTS` wide, and decides in program order where each one goes. Each instruction is inserted into the instruction queue, inserted into the queue along with a load or store queue reservation, placed through the separate non-speculative insert port, or completed in place without ever occupying a scheduling entry. Squashed instructions are dropped.

The instruction queue reports its number of free entries. The unit uses up that count slot by slot within the same cycle. When a slot that needs checking finds no entry left, the walk stops at that slot. The unit then raises a block request towards the upstream stage and reports the slots it did not take as not accepted, so that skid logic can replay them. Six event counters record what the unit did. Steering outputs are combinational from the inputs. The counters update on the following clock edge.

Top module: `dispatch_steer`

## Requirements
- R1: Only slots 0 to `grp_size`-1 are considered, walked from slot 0 upward. A slot at or above `grp_size` produces no strobe and is not accepted, whatever its flags.
- R2: A squashed slot produces no insert or marking strobe, is accepted, uses no free entry and adds one to `cnt_squash`.
- R3: When a non-squashed slot finds the remaining free count at zero, `block_req` is 1. That slot and every later slot produce no strobe and have `accepted` 0, and `cnt_iqfull` rises by one at the next edge. Otherwise `block_req` is 0.
- R4: A load slot drives both `ldq_ins` and `iq_ins` for its position and adds one to `cnt_load`.
- R5: A store slot drives both `stq_ins` and `iq_ins` for its position and adds one to `cnt_store`.
- R6: A non-speculative slot drives `nsp_ins` and `commit_mark`, never `iq_ins`. It uses one free entry and adds one to `cnt_nspec`.
- R7: A nop slot drives `tail_adv`, `exec_mark` and `commit_mark`, uses no free entry, and drives no insert strobe.
- R8: The checks for a slot are made in this fixed order: squashed, then free count zero, then load, then store, then non-speculative, then nop, and otherwise a plain insert. Bit i of each flag or strobe vector belongs to slot i.
- R9: A plain, load or store slot uses one free entry. The free count is used up within the cycle, so no more than `iq_free` slots drive `iq_ins` or `nsp_ins`.
- R10: `cnt_disp` counts the slots that drove `iq_ins`. All six counters are zero after reset and add each cycle's events at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counters |
| grp_size | input | $clog2(N_SLOTS+1) | Number of slots in this cycle's group |
| iq_free | input | FREE_W | Free instruction queue entries |
| f_squash | input | N_SLOTS | Per-slot squashed flag |
| f_load | input | N_SLOTS | Per-slot load flag |
| f_store | input | N_SLOTS | Per-slot store flag |
| f_nspec | input | N_SLOTS | Per-slot non-speculative flag |
| f_nop | input | N_SLOTS | Per-slot nop flag |
| iq_ins | output | N_SLOTS | Instruction queue insert strobes |
| ldq_ins | output | N_SLOTS | Load queue reservation strobes |
| stq_ins | output | N_SLOTS | Store queue reservation strobes |
| nsp_ins | output | N_SLOTS | Non-speculative insert strobes |
| tail_adv | output | N_SLOTS | Queue tail advance without an entry (nop) |
| exec_mark | output | N_SLOTS | Mark issued and executed |
| commit_mark | output | N_SLOTS | Mark ready to commit |
| accepted | output | N_SLOTS | Slot was consumed this cycle |
| block_req | output | 1 | Stall upstream and block |
| cnt_disp | output | CNT_W | Instruction queue inserts |
| cnt_squash | output | CNT_W | Squashed slots dropped |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nspec | output | CNT_W | Non-speculative dispatched |
| cnt_iqfull | output | CNT_W | Cycles halted on a full queue |

## Verification
The assertions assume that `iq_free` is the true number of free entries in the queue. They also assume that the upstream stage replays the unaccepted slots rather than expecting them to have been taken. They do not require the flags to be exclusive, because the priority order resolves any overlap. The stimulus sets the inputs at the falling edge and holds them for a full cycle. It mixes overlapping flags on purpose and keeps `iq_free` within its range, at zero, and below the number of slots that need entries.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [2:0] {
    K_SKIP, K_LOAD, K_STORE, K_NSPEC, K_NOP, K_PLAIN
  } kind_e;

  localparam int NCNT     = 6;
  localparam int C_DISP   = 0;
  localparam int C_SQUASH = 1;
  localparam int C_LOAD   = 2;
  localparam int C_STORE  = 3;
  localparam int C_NSPEC  = 4;
  localparam int C_IQFULL = 5;

  // Static part of the priority order; the free-count check sits between
  // squash and load and is applied by the walker.
  function automatic kind_e kind_of(logic sq, logic ld, logic st,
                                    logic ns, logic np);
    if (sq)      return K_SKIP;
    else if (ld) return K_LOAD;
    else if (st) return K_STORE;
    else if (ns) return K_NSPEC;
    else if (np) return K_NOP;
    else         return K_PLAIN;
  endfunction

  function automatic logic needs_entry(kind_e k);
    return !(k == K_SKIP || k == K_NOP);
  endfunction

endpackage

// File: rtl/dsp_classify.sv
module dsp_classify
  import dsp_pkg::*;
#(
  parameter int N_SLOTS = 4
) (
  input  logic [N_SLOTS-1:0] f_squash,
  input  logic [N_SLOTS-1:0] f_load,
  input  logic [N_SLOTS-1:0] f_store,
  input  logic [N_SLOTS-1:0] f_nspec,
  input  logic [N_SLOTS-1:0] f_nop,
  output kind_e              kind [N_SLOTS]
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign kind[g] = kind_of(f_squash[g], f_load[g], f_store[g],
                             f_nspec[g], f_nop[g]);
  end
endmodule

// File: rtl/dsp_walk.sv
module dsp_walk
  import dsp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int FREE_W  = 5,
  parameter int SZ_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  kind_e              kind [N_SLOTS],
  input  logic [SZ_W-1:0]    grp_size,
  input  logic [FREE_W-1:0]  iq_free,
  output logic [N_SLOTS-1:0] iq_ins,
  output logic [N_SLOTS-1:0] ldq_ins,
  output logic [N_SLOTS-1:0] stq_ins,
  output logic [N_SLOTS-1:0] nsp_ins,
  output logic [N_SLOTS-1:0] tail_adv,
  output logic [N_SLOTS-1:0] exec_mark,
  output logic [N_SLOTS-1:0] commit_mark,
  output logic [N_SLOTS-1:0] accepted,
  output logic [N_SLOTS-1:0] skip_drop,
  output logic               block_req
);
  logic [FREE_W-1:0] left;
  logic              halted;

  always_comb begin
    left        = iq_free;
    halted      = 1'b0;
    iq_ins      = '0;
    ldq_ins     = '0;
    stq_ins     = '0;
    nsp_ins     = '0;
    tail_adv    = '0;
    exec_mark   = '0;
    commit_mark = '0;
    accepted    = '0;
    skip_drop   = '0;
    block_req   = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (i < int'(grp_size) && !halted) begin
        if (kind[i] == K_SKIP) begin
          accepted[i]  = 1'b1;
          skip_drop[i] = 1'b1;
        end else if (left == '0) begin
          halted    = 1'b1;
          block_req = 1'b1;
        end else begin
          accepted[i] = 1'b1;
          unique case (kind[i])
            K_LOAD:  begin ldq_ins[i] = 1'b1; iq_ins[i] = 1'b1; end
            K_STORE: begin stq_ins[i] = 1'b1; iq_ins[i] = 1'b1; end
            K_NSPEC: begin nsp_ins[i] = 1'b1; commit_mark[i] = 1'b1; end
            K_NOP:   begin
              tail_adv[i]    = 1'b1;
              exec_mark[i]   = 1'b1;
              commit_mark[i] = 1'b1;
            end
            default: iq_ins[i] = 1'b1;
          endcase
          if (needs_entry(kind[i])) left = left - 1'b1;
        end
      end
    end
  end

  assert_nspec_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nsp_ins & iq_ins) == '0);
  assert_ldst_in_iq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ldq_ins | stq_ins) & ~iq_ins) == '0);
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iq_ins | nsp_ins) <= int'(iq_free));
  assert_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted & (accepted + 1'b1)) == '0);
  assert_nop_no_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_adv & (iq_ins | nsp_ins)) == '0);
  assert_size_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(accepted) <= int'(grp_size));
endmodule

// File: rtl/dsp_counters.sv
module dsp_counters
  import dsp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SLOTS-1:0]         iq_ins,
  input  logic [N_SLOTS-1:0]         ldq_ins,
  input  logic [N_SLOTS-1:0]         stq_ins,
  input  logic [N_SLOTS-1:0]         nsp_ins,
  input  logic [N_SLOTS-1:0]         skip_drop,
  input  logic                       block_req,
  output logic [NCNT-1:0][CNT_W-1:0] cnt
);
  logic [NCNT-1:0][CNT_W-1:0] inc;

  always_comb begin
    inc           = '0;
    inc[C_DISP]   = CNT_W'($countones(iq_ins));
    inc[C_SQUASH] = CNT_W'($countones(skip_drop));
    inc[C_LOAD]   = CNT_W'($countones(ldq_ins));
    inc[C_STORE]  = CNT_W'($countones(stq_ins));
    inc[C_NSPEC]  = CNT_W'($countones(nsp_ins));
    inc[C_IQFULL] = CNT_W'(block_req);
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[g] <= '0;
      else        cnt[g] <= cnt[g] + inc[g];
    end
  end

  assert_iqfull_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    block_req |=> cnt[C_IQFULL] == CNT_W'($past(cnt[C_IQFULL]) + 1'b1));
  assert_disp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iq_ins == '0 |=> $stable(cnt[C_DISP]));
endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
  import dsp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int FREE_W  = 5,
  parameter int CNT_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(N_SLOTS+1)-1:0]  grp_size,
  input  logic [FREE_W-1:0]             iq_free,
  input  logic [N_SLOTS-1:0]            f_squash,
  input  logic [N_SLOTS-1:0]            f_load,
  input  logic [N_SLOTS-1:0]            f_store,
  input  logic [N_SLOTS-1:0]            f_nspec,
  input  logic [N_SLOTS-1:0]            f_nop,
  output logic [N_SLOTS-1:0]            iq_ins,
  output logic [N_SLOTS-1:0]            ldq_ins,
  output logic [N_SLOTS-1:0]            stq_ins,
  output logic [N_SLOTS-1:0]            nsp_ins,
  output logic [N_SLOTS-1:0]            tail_adv,
  output logic [N_SLOTS-1:0]            exec_mark,
  output logic [N_SLOTS-1:0]            commit_mark,
  output logic [N_SLOTS-1:0]            accepted,
  output logic                          block_req,
  output logic [CNT_W-1:0]              cnt_disp,
  output logic [CNT_W-1:0]              cnt_squash,
  output logic [CNT_W-1:0]              cnt_load,
  output logic [CNT_W-1:0]              cnt_store,
  output logic [CNT_W-1:0]              cnt_nspec,
  output logic [CNT_W-1:0]              cnt_iqfull
);
  localparam int SZ_W = $clog2(N_SLOTS + 1);

  kind_e                      kind [N_SLOTS];
  logic [N_SLOTS-1:0]         skip_drop;
  logic [NCNT-1:0][CNT_W-1:0] cnt;

  dsp_classify #(.N_SLOTS(N_SLOTS)) u_cls (
    .f_squash(f_squash), .f_load(f_load), .f_store(f_store),
    .f_nspec(f_nspec), .f_nop(f_nop), .kind(kind)
  );

  dsp_walk #(.N_SLOTS(N_SLOTS), .FREE_W(FREE_W), .SZ_W(SZ_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .kind(kind), .grp_size(grp_size),
    .iq_free(iq_free), .iq_ins(iq_ins), .ldq_ins(ldq_ins),
    .stq_ins(stq_ins), .nsp_ins(nsp_ins), .tail_adv(tail_adv),
    .exec_mark(exec_mark), .commit_mark(commit_mark),
    .accepted(accepted), .skip_drop(skip_drop), .block_req(block_req)
  );

  dsp_counters #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .iq_ins(iq_ins), .ldq_ins(ldq_ins),
    .stq_ins(stq_ins), .nsp_ins(nsp_ins), .skip_drop(skip_drop),
    .block_req(block_req), .cnt(cnt)
  );

  assign cnt_disp   = cnt[C_DISP];
  assign cnt_squash = cnt[C_SQUASH];
  assign cnt_load   = cnt[C_LOAD];
  assign cnt_store  = cnt[C_STORE];
  assign cnt_nspec  = cnt[C_NSPEC];
  assign cnt_iqfull = cnt[C_IQFULL];

  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_squash & accepted) & (iq_ins | nsp_ins | tail_adv | commit_mark)) == '0);
endmodule

// File: tb/dispatch_steer_tb_top.sv
module dispatch_steer_tb_top;
  localparam int N = 4;
  localparam int FW = 5;
  localparam int CW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] grp_size = '0;
  logic [FW-1:0] iq_free = '0;
  logic [N-1:0] f_squash = '0, f_load = '0, f_store = '0, f_nspec = '0, f_nop = '0;
  logic [N-1:0] iq_ins, ldq_ins, stq_ins, nsp_ins, tail_adv, exec_mark, commit_mark, accepted;
  logic block_req;
  logic [CW-1:0] cnt_disp, cnt_squash, cnt_load, cnt_store, cnt_nspec, cnt_iqfull;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dispatch_steer #(.N_SLOTS(N), .FREE_W(FW), .CNT_W(CW)) dut_i (.*);

  // expected state
  logic [N-1:0] e_iq, e_ld, e_st, e_ns, e_tail, e_exec, e_cm, e_acc;
  logic e_blk;
  int e_disp = 0, e_sq = 0, e_load = 0, e_store = 0, e_nspec = 0, e_full = 0;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model from the requirements: walk slots in order, priority squash >
  // no free entry > load > store > nspec > nop > plain.
  task automatic model();
    int left = int'(iq_free);
    bit stop = 0;
    {e_iq, e_ld, e_st, e_ns, e_tail, e_exec, e_cm, e_acc} = '0;
    e_blk = 0;
    for (int i = 0; i < N; i++) begin
      if (i >= int'(grp_size) || stop) continue;
      if (f_squash[i]) begin e_acc[i] = 1; e_sq++; end
      else if (left == 0) begin stop = 1; e_blk = 1; end
      else begin
        e_acc[i] = 1;
        if (f_load[i]) begin e_ld[i] = 1; e_iq[i] = 1; left--; e_load++; end
        else if (f_store[i]) begin e_st[i] = 1; e_iq[i] = 1; left--; e_store++; end
        else if (f_nspec[i]) begin e_ns[i] = 1; e_cm[i] = 1; left--; e_nspec++; end
        else if (f_nop[i]) begin e_tail[i] = 1; e_exec[i] = 1; e_cm[i] = 1; end
        else begin e_iq[i] = 1; left--; end
      end
    end
    e_disp += $countones(e_iq);
    if (e_blk) e_full++;
  endtask

  // Inputs already set just after a falling edge.
  task automatic step(string req);
    model();
    #1;
    chk(req, "iq_ins", iq_ins, e_iq);
    chk(req, "ldq_ins", ldq_ins, e_ld);
    chk(req, "stq_ins", stq_ins, e_st);
    chk(req, "nsp_ins", nsp_ins, e_ns);
    chk(req, "tail_adv", tail_adv, e_tail);
    chk(req, "exec_mark", exec_mark, e_exec);
    chk(req, "commit_mark", commit_mark, e_cm);
    chk(req, "accepted", accepted, e_acc);
    chk(req, "block_req", block_req, e_blk);
    @(posedge clk); #1;
    chk("R10", "cnt_disp", cnt_disp, e_disp);
    chk("R2", "cnt_squash", cnt_squash, e_sq);
    chk("R4", "cnt_load", cnt_load, e_load);
    chk("R5", "cnt_store", cnt_store, e_store);
    chk("R6", "cnt_nspec", cnt_nspec, e_nspec);
    chk("R3", "cnt_iqfull", cnt_iqfull, e_full);
    @(negedge clk);
  endtask

  task automatic set(int sz, int fr, logic [N-1:0] sq, ld, st, ns, np);
    grp_size = 3'(sz); iq_free = FW'(fr);
    f_squash = sq; f_load = ld; f_store = st; f_nspec = ns; f_nop = np;
  endtask

  task automatic t_reset();
    chk("R10", "reset cnt_disp", cnt_disp, 0);
    chk("R10", "reset cnt_iqfull", cnt_iqfull, 0);
    set(0, 8, '0, '0, '0, '0, '0); step("R1");
  endtask
  task automatic t_plain();  set(4, 8, '0, '0, '0, '0, '0); step("R10"); endtask
  task automatic t_size();   set(2, 8, 4'b0000, 4'b0100, 4'b1000, '0, '0); step("R1"); endtask
  task automatic t_squash(); set(4, 3, 4'b0010, '0, '0, '0, '0); step("R2"); endtask
  task automatic t_full();   set(4, 2, '0, '0, '0, '0, '0); step("R3"); endtask
  task automatic t_full0();  set(4, 0, 4'b0001, '0, '0, '0, '0); step("R3"); endtask
  task automatic t_ldst();   set(4, 8, '0, 4'b0101, 4'b0110, '0, '0); step("R4"); endtask
  task automatic t_store();  set(3, 8, '0, '0, 4'b0011, 4'b0100, '0); step("R5"); endtask
  task automatic t_nspec();  set(4, 2, '0, '0, '0, 4'b0011, 4'b0100); step("R6"); endtask
  task automatic t_nop();    set(4, 1, '0, '0, '0, '0, 4'b0111); step("R7"); endtask
  task automatic t_nopfull(); set(4, 0, '0, '0, '0, '0, 4'b1111); step("R8"); endtask
  task automatic t_prio();   set(4, 8, 4'b0001, 4'b0011, 4'b0110, 4'b1110, 4'b1111); step("R8"); endtask
  task automatic t_budget(); set(4, 3, '0, 4'b0001, 4'b0010, 4'b0100, '0); step("R9"); endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_plain(); t_size(); t_squash(); t_full(); t_full0();
    t_ldst(); t_store(); t_nspec(); t_nop(); t_nopfull(); t_prio(); t_budget();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule